// File: doc/BRIEF.md
# E1 Timeslot-0 Spare-Bit Transmit Inserter

This block builds the first timeslot of every outgoing E1 frame and leaves the rest of the frame alone. Bit by bit, it merges three sources into one serial output. The first is an image of host-written values, captured once per double frame. The second is an external link input, which can supply any chosen subset of the five national spare bits. The third is the serial data input, which carries the payload and can also carry the international bit. The two frames of each double frame alternate: first the align frame, which holds the fixed alignment word, then the non-align frame, which holds the spare bits.

The host provides two values. One is the international bit used in the align frame. The other is a full byte for the non-align frame. The block captures both on the last bit of every double frame and raises a one-cycle status flag at the same edge. The host then has one whole double frame to present new values; if it presents none, the captured values are sent again. A five-bit select routes each spare bit either from the captured byte or from the link input. The international bit position follows a fixed priority: CRC bit, then E-bit, then serial data, then the host value. The CRC and E-bit values come in on input ports, so CRC-4 generation is not part of this block.

The block handles one bit per clock. The output is registered, so each bit appears on the output one clock after the inputs that formed it.

Top module: `e1_ts0_inserter`

## Requirements
- R1: While `rst` is high, and until the first clock after it falls, `ser_out` and `af_flag` are 0. The bit counter restarts at bit 0 of an align frame, and the captured host image is all zeros.
- R2: For every bit position from 8 to FRAME_BITS-1, `ser_out` equals the `ser_in` value of the previous clock.
- R3: In an align frame, positions 1 to 7 carry the fixed word 0011011, first bit first, whatever the inputs are.
- R4: In a non-align frame, positions 1 and 2 carry bits 6 and 5 of the captured non-align byte.
- R5: In a non-align frame, positions 3 to 7 are the spare bits. Position p is tied to byte bit 7-p. It carries `link_in` when `sa_sel[7-p]` is 1, and byte bit 7-p when `sa_sel[7-p]` is 0.
- R6: Position 0 of either frame follows this priority. If `crc4_en` is 1, it carries `crc_bit`. Otherwise, if `ebit_en` is 1, it carries `ebit_in`. Otherwise, if `si_use_reg` is 0, it carries `ser_in`. Otherwise it carries the captured host value: `host_af_si` in an align frame, and bit 7 of the non-align byte in a non-align frame.
- R7: `af_flag` is high for exactly one clock in every 2*FRAME_BITS clocks. It is high together with the last bit of each non-align frame, and it is first high 2*FRAME_BITS clocks after reset ends. In the clock after the flag, the output carries position 0 of an align frame.
- R8: The host values are captured only at the edge that raises `af_flag`. Changes to them at any other time do not reach the output, so the previously captured values are retransmitted.
- R9: With `sa_sel` all ones and `link_in` tied to `ser_in`, the spare-bit positions pass `ser_in` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data input (payload, optional international bit) |
| link_in | input | 1 | External source for selected spare bits |
| host_af_si | input | 1 | Host international bit for the align frame |
| host_naf | input | 8 | Host non-align byte, bit 7 sent first |
| sa_sel | input | SA_COUNT | Per-spare-bit source select, 1 = link input |
| si_use_reg | input | 1 | 1 = international bit from host value, 0 = from serial data |
| crc4_en | input | 1 | CRC-4 mode override of the international bit |
| crc_bit | input | 1 | CRC bit value used when `crc4_en` is set |
| ebit_en | input | 1 | Automatic E-bit override of the international bit |
| ebit_in | input | 1 | E-bit value used when `ebit_en` is set |
| ser_out | output | 1 | Registered serial output |
| af_flag | output | 1 | One-cycle pulse when host values are captured |

## Verification
The hardest case to reach from the ports is the retransmission case. To show it, the host inputs have to change while the captured copy must not follow them. The bench drives new random host values on every clock for whole double frames. Its reference model latches them only at the flag edge, so any early or late capture shows up as a spare-bit or international-bit mismatch. The priority chain of the international bit is reached by drawing its three enables at random on every clock. This covers all eight enable combinations, in both frame types.

// File: rtl/e1ts0_pkg.sv
package e1ts0_pkg;

  localparam int TS_BITS = 8;

  // Alignment word in bits 6..0, first-sent bit at 6; bit 7 is a placeholder.
  localparam logic [7:0] FAS_BYTE = 8'b0001_1011;

  typedef enum logic {
    FRM_ALIGN    = 1'b0,
    FRM_NONALIGN = 1'b1
  } frame_e;

  typedef struct packed {
    logic       af_si;
    logic [7:0] naf;
  } host_img_t;

  function automatic logic fas_bit(input logic [2:0] idx);
    logic [2:0] k;
    k = 3'd7 - idx;
    return FAS_BYTE[k];
  endfunction

endpackage

// File: rtl/e1ts0_timing.sv
module e1ts0_timing
  import e1ts0_pkg::*;
#(
  parameter int FRAME_BITS = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic [$clog2(FRAME_BITS)-1:0] pos,
  output frame_e                        frm,
  output logic [2:0]                    ts_idx,
  output logic                          in_ts0,
  output logic                          dbl_end
);

  localparam int POS_W = $clog2(FRAME_BITS);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] TSW  = POS_W'(TS_BITS);

  logic frame_end;

  assign frame_end = (pos == LAST);
  assign dbl_end   = frame_end && (frm == FRM_NONALIGN);
  assign in_ts0    = (pos < TSW);
  assign ts_idx    = pos[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      frm <= FRM_ALIGN;
    end else if (frame_end) begin
      pos <= '0;
      frm <= (frm == FRM_ALIGN) ? FRM_NONALIGN : FRM_ALIGN;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (pos == LAST) |=> (pos == '0 && frm != $past(frm)));

  assert_range_R7: assert property (@(posedge clk) disable iff (rst)
    (pos <= LAST));

endmodule

// File: rtl/e1ts0_shadow.sv
module e1ts0_shadow
  import e1ts0_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       host_af_si,
  input  logic [7:0] host_naf,
  output host_img_t  img,
  output logic       af_flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      img     <= '0;
      af_flag <= 1'b0;
    end else begin
      af_flag <= load;
      if (load) begin
        img.af_si <= host_af_si;
        img.naf   <= host_naf;
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(img));

  assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> (img.naf == $past(host_naf) && img.af_si == $past(host_af_si)));

endmodule

// File: rtl/e1ts0_bitmux.sv
module e1ts0_bitmux
  import e1ts0_pkg::*;
#(
  parameter int SA_COUNT = 5
) (
  input  logic                in_ts0,
  input  logic [2:0]          ts_idx,
  input  frame_e              frm,
  input  host_img_t           img,
  input  logic                ser_in,
  input  logic                link_in,
  input  logic [SA_COUNT-1:0] sa_sel,
  input  logic                si_use_reg,
  input  logic                crc4_en,
  input  logic                crc_bit,
  input  logic                ebit_en,
  input  logic                ebit_in,
  output logic                nxt_bit
);

  logic [6:0] naf_eff;
  logic       si_bit;
  logic       si_reg;
  logic [2:0] bsel;

  // Spare positions pick register or link per bit; the rest follow the byte.
  for (genvar j = 0; j < 7; j++) begin : g_naf
    if (j < SA_COUNT) begin : g_sa
      assign naf_eff[j] = sa_sel[j] ? link_in : img.naf[j];
    end else begin : g_fixed
      assign naf_eff[j] = img.naf[j];
    end
  end

  assign si_reg = (frm == FRM_ALIGN) ? img.af_si : img.naf[7];

  always_comb begin
    if (crc4_en)          si_bit = crc_bit;
    else if (ebit_en)     si_bit = ebit_in;
    else if (!si_use_reg) si_bit = ser_in;
    else                  si_bit = si_reg;
  end

  assign bsel = 3'd7 - ts_idx;

  always_comb begin
    if (!in_ts0)                nxt_bit = ser_in;
    else if (ts_idx == 3'd0)    nxt_bit = si_bit;
    else if (frm == FRM_ALIGN)  nxt_bit = fas_bit(ts_idx);
    else                        nxt_bit = naf_eff[bsel];
  end

endmodule

// File: rtl/e1_ts0_inserter.sv
module e1_ts0_inserter
  import e1ts0_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SA_COUNT   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_in,
  input  logic                link_in,
  input  logic                host_af_si,
  input  logic [7:0]          host_naf,
  input  logic [SA_COUNT-1:0] sa_sel,
  input  logic                si_use_reg,
  input  logic                crc4_en,
  input  logic                crc_bit,
  input  logic                ebit_en,
  input  logic                ebit_in,
  output logic                ser_out,
  output logic                af_flag
);

  localparam int POS_W = $clog2(FRAME_BITS);

  logic [POS_W-1:0] pos;
  frame_e           frm;
  logic [2:0]       ts_idx;
  logic             in_ts0;
  logic             dbl_end;
  host_img_t        img;
  logic             nxt_bit;
  logic             fas_now;

  e1ts0_timing #(.FRAME_BITS(FRAME_BITS)) u_timing (
    .clk     (clk),
    .rst     (rst),
    .pos     (pos),
    .frm     (frm),
    .ts_idx  (ts_idx),
    .in_ts0  (in_ts0),
    .dbl_end (dbl_end)
  );

  e1ts0_shadow u_shadow (
    .clk        (clk),
    .rst        (rst),
    .load       (dbl_end),
    .host_af_si (host_af_si),
    .host_naf   (host_naf),
    .img        (img),
    .af_flag    (af_flag)
  );

  e1ts0_bitmux #(.SA_COUNT(SA_COUNT)) u_mux (
    .in_ts0     (in_ts0),
    .ts_idx     (ts_idx),
    .frm        (frm),
    .img        (img),
    .ser_in     (ser_in),
    .link_in    (link_in),
    .sa_sel     (sa_sel),
    .si_use_reg (si_use_reg),
    .crc4_en    (crc4_en),
    .crc_bit    (crc_bit),
    .ebit_en    (ebit_en),
    .ebit_in    (ebit_in),
    .nxt_bit    (nxt_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) ser_out <= 1'b0;
    else     ser_out <= nxt_bit;
  end

  assign fas_now = fas_bit(ts_idx);

  assert_payload_R2: assert property (@(posedge clk) disable iff (rst)
    !in_ts0 |=> (ser_out == $past(ser_in)));

  assert_fas_R3: assert property (@(posedge clk) disable iff (rst)
    (in_ts0 && frm == FRM_ALIGN && ts_idx != 3'd0) |=> (ser_out == $past(fas_now)));

  assert_crc_R6: assert property (@(posedge clk) disable iff (rst)
    (in_ts0 && ts_idx == 3'd0 && crc4_en) |=> (ser_out == $past(crc_bit)));

  assert_ebit_R6: assert property (@(posedge clk) disable iff (rst)
    (in_ts0 && ts_idx == 3'd0 && !crc4_en && ebit_en) |=> (ser_out == $past(ebit_in)));

  assert_flag_R7: assert property (@(posedge clk) disable iff (rst)
    af_flag |-> (pos == '0 && frm == FRM_ALIGN));

endmodule

// File: tb/e1_ts0_inserter_tb.sv
module e1_ts0_inserter_tb_top;

  localparam int FRAME_BITS = 256;
  localparam int SA_COUNT   = 5;
  localparam logic [7:0] FAS = 8'b0001_1011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0, link_in = 1'b0, host_af_si = 1'b0;
  logic [7:0] host_naf = 8'h00;
  logic [SA_COUNT-1:0] sa_sel = '0;
  logic si_use_reg = 1'b1, crc4_en = 1'b0, crc_bit = 1'b0;
  logic ebit_en = 1'b0, ebit_in = 1'b0;
  logic ser_out, af_flag;

  int checks = 0;
  int fails  = 0;
  int phase  = 0;
  bit done   = 1'b0;

  // Reference model state
  int    m_pos = 0;
  int    m_frm = 0;
  logic  m_af_si = 1'b0;
  logic [7:0] m_naf = 8'h00;
  logic  exp_out = 1'b0;
  logic  exp_flag = 1'b0;
  string exp_tag = "R1";

  always #4 clk = ~clk;

  e1_ts0_inserter #(.FRAME_BITS(FRAME_BITS), .SA_COUNT(SA_COUNT)) dut_i (
    .clk(clk), .rst(rst), .ser_in(ser_in), .link_in(link_in),
    .host_af_si(host_af_si), .host_naf(host_naf), .sa_sel(sa_sel),
    .si_use_reg(si_use_reg), .crc4_en(crc4_en), .crc_bit(crc_bit),
    .ebit_en(ebit_en), .ebit_in(ebit_in), .ser_out(ser_out), .af_flag(af_flag)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_frm = 0; m_af_si = 1'b0; m_naf = 8'h00;
      exp_out = 1'b0; exp_flag = 1'b0; exp_tag = "R1";
    end else begin
      if (m_pos >= 8) begin
        exp_out = ser_in; exp_tag = "R2";
      end else if (m_pos == 0) begin
        exp_tag = "R6";
        if (crc4_en)          exp_out = crc_bit;
        else if (ebit_en)     exp_out = ebit_in;
        else if (!si_use_reg) exp_out = ser_in;
        else begin
          exp_out = (m_frm == 0) ? m_af_si : m_naf[7];
          if (phase == 1) exp_tag = "R8";
        end
      end else if (m_frm == 0) begin
        exp_out = FAS[7 - m_pos]; exp_tag = "R3";
      end else if (m_pos <= 2) begin
        exp_out = m_naf[7 - m_pos];
        exp_tag = (phase == 1) ? "R8" : "R4";
      end else begin
        if (sa_sel[7 - m_pos]) exp_out = link_in;
        else                   exp_out = m_naf[7 - m_pos];
        if (phase == 3)      exp_tag = "R9";
        else if (phase == 1) exp_tag = "R8";
        else                 exp_tag = "R5";
      end
      exp_flag = (m_pos == FRAME_BITS - 1) && (m_frm == 1);
      if (exp_flag) begin
        m_af_si = host_af_si; m_naf = host_naf;
      end
      if (m_pos == FRAME_BITS - 1) begin
        m_pos = 0; m_frm = 1 - m_frm;
      end else begin
        m_pos = m_pos + 1;
      end
    end
  end

  task automatic check_bit(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic run_cycles(input int n, input bit rand_host, input bit rand_si);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_bit(exp_tag, ser_out, exp_out);
      check_bit("R7", af_flag, exp_flag);
      ser_in = $urandom_range(0, 1);
      if (phase == 3) link_in = ser_in;
      else            link_in = $urandom_range(0, 1);
      crc_bit = $urandom_range(0, 1);
      ebit_in = $urandom_range(0, 1);
      if (rand_host) begin
        host_af_si = $urandom_range(0, 1);
        host_naf   = 8'($urandom_range(0, 255));
      end
      if (rand_si) begin
        si_use_reg = $urandom_range(0, 1);
        crc4_en    = ($urandom_range(0, 3) == 0);
        ebit_en    = ($urandom_range(0, 2) == 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    check_bit("R1", ser_out, 1'b0);
    check_bit("R1", af_flag, 1'b0);
    rst = 1'b0;
    // R1, R2-R5, R7: idle host values, Si from register
    phase = 0;
    run_cycles(4 * FRAME_BITS, 1'b0, 1'b0);
    // R8: host values move every cycle; only the flag-edge capture counts
    phase = 1;
    sa_sel = 5'b01010;
    run_cycles(6 * FRAME_BITS, 1'b1, 1'b0);
    // R5, R6: random spare selects and Si priority inputs
    phase = 2;
    for (int k = 0; k < 4; k++) begin
      sa_sel = SA_COUNT'($urandom_range(0, 31));
      host_naf = 8'($urandom_range(0, 255));
      host_af_si = $urandom_range(0, 1);
      run_cycles(2 * FRAME_BITS, 1'b0, 1'b1);
    end
    // R9: all spare bits from link, link looped from serial data
    phase = 3;
    sa_sel = '1; si_use_reg = 1'b1; crc4_en = 1'b0; ebit_en = 1'b0;
    host_naf = 8'h00;
    run_cycles(4 * FRAME_BITS, 1'b0, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule